// File: doc/BRIEF.md
# Binary Tape Word Assembler

This block sits behind a serial byte receiver and rebuilds 18-bit machine words from binary paper-tape characters. Every received character arrives as an 8-bit byte qualified by a valid indication. A character whose most significant bit is clear carries no data and is thrown away without trace. A character with that bit set is a data character. Its six low bits form one payload. Three payloads, taken in arrival order, make up one word. The first payload lands in the most significant six bits of the word.

When the third payload of a word has been taken, the block presents the finished word together with a one-cycle word-valid strobe. A synchronous clear input abandons any partly built word. By a build-time parameter, the valid input is treated either as a one-cycle pulse or as a completion level whose rising edge marks a new character. In the target system the characters come from an 8N1 link at 115200 baud next to a 50 MHz clock, so a new character arrives at most once every few thousand cycles. The logic does not rely on that spacing.

Top module: `tape_word_asm`

## Requirements
- R1: After reset, `word_vld_o` is 0, `word_o` is 0 and the block waits for the first payload of a word.
- R2: A qualified character with bit 7 equal to 0 is ignored. It does not raise `word_vld_o`, does not advance the payload position and does not alter the partial word.
- R3: A qualified character with bit 7 equal to 1 contributes its bits 5..0 as a payload. Bit 6 has no effect on any word.
- R4: The first accepted payload of a word becomes `word_o[17:12]`, the second `word_o[11:6]` and the third `word_o[5:0]`. For example, payloads 000101, 000110 and 111000 yield octal 050670.
- R5: `word_vld_o` is high for exactly one cycle, in the cycle right after the edge that accepts the third payload, and `word_o` holds the new word in that cycle. `word_o` changes only when `word_vld_o` rises.
- R6: After a word is emitted, the payload position returns to the start, so the next accepted payload begins a new word.
- R7: While `clr_i` is 1 at a clock edge, the payload position and the partial word reset, `word_vld_o` is 0 in the following cycle, and a character qualified in that same cycle is dropped.
- R8: With the level strobe mode selected, a character is taken only on a 0-to-1 transition of `byte_vld_i`. Holding the level high for several cycles takes the character once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_i | input | 1 | Synchronous clear of the word in progress |
| byte_i | input | BYTE_W (8) | Received character |
| byte_vld_i | input | 1 | Character qualifier: a one-cycle pulse or a completion level, depending on the mode |
| word_o | output | SLICE_W*SLICES (18) | Last assembled word |
| word_vld_o | output | 1 | One-cycle strobe marking a new word |

## Verification
The assertions assume that `byte_i` is stable whenever it is qualified. In pulse mode they also assume that a pulse marks exactly one character, so a word strobe can always be traced back to a data character accepted one edge earlier with no clear present. The random stimulus always drives the byte together with its qualifier. It returns the qualifier to zero for a cycle between characters and asserts the clear only on some characters. Level mode is driven in a directed sequence that holds the level high for several cycles per character, which exercises edge detection inside the same input rules.

// File: rtl/tw_pkg.sv
package tw_pkg;

  // How the character qualifier input is interpreted.
  typedef enum logic {
    STB_PULSE = 1'b0,  // one-cycle pulse per character
    STB_LEVEL = 1'b1   // completion level, rising edge marks a character
  } stb_mode_e;

  // Width of the payload slot counter for a given slice count.
  function automatic int slot_bits(input int slices);
    return (slices < 2) ? 1 : $clog2(slices);
  endfunction

endpackage

// File: rtl/tw_strobe_gen.sv
module tw_strobe_gen
  import tw_pkg::*;
#(
  parameter stb_mode_e STB_MODE = STB_PULSE
) (
  input  logic clk,
  input  logic rst,
  input  logic vld_i,
  output logic stb_o
);

  generate
    if (STB_MODE == STB_LEVEL) begin : g_level
      logic vld_q;
      always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= vld_i;
      end
      assign stb_o = vld_i & ~vld_q;
    end else begin : g_pulse
      assign stb_o = vld_i;
    end
  endgenerate

endmodule

// File: rtl/tw_char_filter.sv
module tw_char_filter #(
  parameter int BYTE_W  = 8,
  parameter int SLICE_W = 6
) (
  input  logic               stb_i,
  input  logic               clr_i,
  input  logic [BYTE_W-1:0]  char_i,
  output logic               take_o,
  output logic [SLICE_W-1:0] payload_o
);

  localparam int FLAG_BIT = BYTE_W - 1;

  // Only flagged characters carry data; a clear in the same cycle wins.
  assign take_o    = stb_i & char_i[FLAG_BIT] & ~clr_i;
  assign payload_o = char_i[SLICE_W-1:0];

endmodule

// File: rtl/tw_slice_packer.sv
module tw_slice_packer #(
  parameter int SLICE_W = 6,
  parameter int SLICES  = 3,
  parameter int CNT_W   = 2,
  localparam int WORD_W = SLICE_W * SLICES,
  localparam int ACC_W  = WORD_W - SLICE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               take_i,
  input  logic [SLICE_W-1:0] payload_i,
  output logic [WORD_W-1:0]  word_o,
  output logic               word_vld_o,
  output logic [CNT_W-1:0]   slot_o
);

  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLICES - 1);

  logic [ACC_W-1:0]  acc_q;
  logic [CNT_W-1:0]  slot_q;
  logic [WORD_W-1:0] joined;

  assign joined = {acc_q, payload_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= '0;
      slot_q     <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else if (clr_i) begin
      acc_q      <= '0;
      slot_q     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (take_i) begin
        if (slot_q == LAST_SLOT) begin
          word_o     <= joined;
          word_vld_o <= 1'b1;
          acc_q      <= '0;
          slot_q     <= '0;
        end else begin
          acc_q  <= joined[ACC_W-1:0];
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  assign slot_o = slot_q;

endmodule

// File: rtl/tape_word_asm.sv
module tape_word_asm
  import tw_pkg::*;
#(
  parameter int        BYTE_W   = 8,
  parameter int        SLICE_W  = 6,
  parameter int        SLICES   = 3,
  parameter stb_mode_e STB_MODE = STB_PULSE,
  localparam int       WORD_W   = SLICE_W * SLICES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);

  localparam int CNT_W = slot_bits(SLICES);

  logic               chr_stb;
  logic               take;
  logic [SLICE_W-1:0] payload;
  logic [CNT_W-1:0]   slot;

  tw_strobe_gen #(.STB_MODE(STB_MODE)) u_stb (
    .clk   (clk),
    .rst   (rst),
    .vld_i (byte_vld_i),
    .stb_o (chr_stb)
  );

  tw_char_filter #(.BYTE_W(BYTE_W), .SLICE_W(SLICE_W)) u_filt (
    .stb_i     (chr_stb),
    .clr_i     (clr_i),
    .char_i    (byte_i),
    .take_o    (take),
    .payload_o (payload)
  );

  tw_slice_packer #(.SLICE_W(SLICE_W), .SLICES(SLICES), .CNT_W(CNT_W)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr_i),
    .take_i     (take),
    .payload_i  (payload),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .slot_o     (slot)
  );

endmodule

// File: rtl/tape_word_asm_chk.sv
module tape_word_asm_chk #(
  parameter int BYTE_W  = 8,
  parameter int WORD_W  = 18,
  parameter int SLICES  = 3,
  parameter int CNT_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_i,
  input logic [BYTE_W-1:0] byte_i,
  input logic [WORD_W-1:0] word_o,
  input logic              word_vld_o,
  input logic              chr_stb,
  input logic [CNT_W-1:0]  slot
);

  // R5: a word strobe follows an accepted data character with no clear
  assert_vld_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |-> $past(chr_stb && byte_i[BYTE_W-1] && !clr_i));

  // R5: strobe lasts a single cycle
  assert_vld_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |=> !word_vld_o);

  // R5: word output changes only together with the strobe
  assert_word_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_o) |-> word_vld_o);

  // R2: a rejected character leaves the slot position alone
  assert_reject_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (chr_stb && !byte_i[BYTE_W-1] && !clr_i) |=> ($stable(slot) && !word_vld_o));

  // R7: clear restarts the word and suppresses the strobe
  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (slot == '0 && !word_vld_o));

  // R6: slot stays in range and is back at zero with each word
  assert_slot_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (int'(slot) < SLICES) && (!word_vld_o || slot == '0));

endmodule

bind tape_word_asm tape_word_asm_chk #(
  .BYTE_W (BYTE_W),
  .WORD_W (WORD_W),
  .SLICES (SLICES),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_i      (clr_i),
  .byte_i     (byte_i),
  .word_o     (word_o),
  .word_vld_o (word_vld_o),
  .chr_stb    (chr_stb),
  .slot       (slot)
);

// File: tb/tape_word_asm_tb.sv
module tape_word_asm_tb;
  import tw_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic [7:0]  bt  = '0;
  logic        bv  = 1'b0;
  logic [17:0] wd;
  logic        wv;

  logic [7:0]  lb  = '0;
  logic        lv  = 1'b0;
  logic [17:0] lwd;
  logic        lwv;

  int n_chk  = 0;
  int n_fail = 0;

  // model state
  int         m_cnt = 0;
  logic [5:0] m_p0 = '0, m_p1 = '0;

  always #2.5 clk = ~clk;

  tape_word_asm u_dut (
    .clk(clk), .rst(rst), .clr_i(clr), .byte_i(bt), .byte_vld_i(bv),
    .word_o(wd), .word_vld_o(wv)
  );

  tape_word_asm #(.STB_MODE(STB_LEVEL)) u_dut_lvl (
    .clk(clk), .rst(rst), .clr_i(1'b0), .byte_i(lb), .byte_vld_i(lv),
    .word_o(lwd), .word_vld_o(lwv)
  );

  function automatic logic [17:0] pack3(input logic [5:0] a, input logic [5:0] b,
                                        input logic [5:0] c);
    return {a, b, c};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [17:0] act,
                     input logic [17:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %o expected %o", req, act, exp);
    end
  endtask

  // Apply one character (or clear) for one cycle, then idle, and check.
  task automatic put(input logic [7:0] b, input logic v, input logic c);
    logic        exp_v;
    logic [17:0] exp_w;
    @(negedge clk);
    chk(wv == 1'b0, "R5 strobe ended", 18'(wv), 18'd0);
    bt = b; bv = v; clr = c;
    exp_v = 1'b0; exp_w = '0;
    if (c) begin
      m_cnt = 0; m_p0 = '0; m_p1 = '0;
    end else if (v && b[7]) begin
      if (m_cnt == 0)      begin m_p0 = b[5:0]; m_cnt = 1; end
      else if (m_cnt == 1) begin m_p1 = b[5:0]; m_cnt = 2; end
      else begin
        exp_w = pack3(m_p0, m_p1, b[5:0]); exp_v = 1'b1; m_cnt = 0;
      end
    end
    @(negedge clk);
    bv = 1'b0; clr = 1'b0;
    chk(wv == exp_v, c ? "R7 strobe after clear" :
                     (v && !b[7]) ? "R2 reject no strobe" : "R5 strobe timing",
        18'(wv), 18'(exp_v));
    if (exp_v) chk(wd == exp_w, "R4 word value", wd, exp_w);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int pulses;
    logic [17:0] seen;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(wv == 1'b0, "R1 strobe low", 18'(wv), 18'd0);
    chk(wd == 18'd0, "R1 word zero", wd, 18'd0);

    // R4 example with an interleaved rejected character (R2)
    put(8'h85, 1, 0);
    put(8'h3F, 1, 0);
    put(8'h86, 1, 0);
    put(8'hB8, 1, 0);
    chk(wd == 18'o050670, "R4 example 050670", wd, 18'o050670);

    // R3 bit 6 ignored; R6 new word starts fresh
    put(8'hC5, 1, 0);
    put(8'hC6, 1, 0);
    put(8'hF8, 1, 0);
    chk(wd == 18'o050670, "R3 bit6 ignored", wd, 18'o050670);

    // R7 clear mid-word with a character in the same cycle
    put(8'h81, 1, 0);
    put(8'h82, 1, 1);
    put(8'h83, 1, 0);
    put(8'h84, 1, 0);
    put(8'h85, 1, 0);
    chk(wd == 18'o030405, "R7 clear drops partial", wd, 18'o030405);

    // R2 a burst of rejected characters changes nothing
    for (int i = 0; i < 6; i++) put(8'h7F, 1, 0);
    chk(wd == 18'o030405, "R2 word held", wd, 18'o030405);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] rb;
      rb = 8'($urandom);
      put(rb, ($urandom % 8) != 0, ($urandom % 20) == 0);
    end

    // R8 level mode: each character held high for three cycles
    pulses = 0; seen = '0;
    foreach (lb[i]) begin end
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      lb = 8'h80 | 8'(k); lv = 1'b1;
      for (int j = 0; j < 5; j++) begin
        @(negedge clk);
        if (j == 2) lv = 1'b0;
        if (lwv) begin pulses++; seen = lwd; end
      end
    end
    chk(pulses == 1, "R8 one word from held levels", 18'(pulses), 18'd1);
    chk(seen == 18'o010203, "R8 level word", seen, 18'o010203);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule